// File: doc/BRIEF.md
# Multi-Converter Test Pattern Checker

This block sits at the end of a data-converter receive path and checks known test data on a bus of M converter lanes. Each lane is S*WIDTH_MULP*N bits wide and carries K = S*WIDTH_MULP sample slots of N bits each, with slot 0 in the least significant bits. A single `in_valid` qualifies the whole bus. A build-time parameter selects one of two checks. Ramp mode checks an incrementing count that takes its start value from the data. PRBS mode checks a pseudo-random bit stream that the block synchronizes to from the data once the link reports deskew alignment.

For every lane the block keeps a sticky error flag, a saturating count of erroneous words and a lock flag. In ramp mode it also keeps a sticky flag that records a difference between lanes. A synchronous clear, or the reset, returns every lane to the unseeded state. It is used in bring-up and loopback tests: a stimulus source sends the pattern, and software or a bench reads the flags and counts.

Top module: `pattern_checker`

## Requirements
- R1: In both modes the first valid word a lane accepts after reset or clear is that lane's seed. In ramp mode, slot 0 of that word sets the reference. The seed word never counts as an error and does not count toward lock.
- R2: In ramp mode, after seeding, slot k (bits k*N+N-1 down to k*N) of each valid word must equal reference+k. The reference for the next valid word is the previous reference plus K. A word with any mismatching slot is erroneous.
- R3: Ramp arithmetic is modulo 2^N, so the value after 2^N-1 is 0 (0xFFFF to 0x0000 for N=16), and this is not an error.
- R4: In ramp mode, a valid word whose lane data differs from lane 0 on any lane sets `xconv_err`, and it stays set. A word corrupted identically on all lanes sets the per-lane flags but not `xconv_err`. In PRBS mode `xconv_err` stays 0.
- R5: In PRBS mode a lane seeds only on a valid word with `deskew_ok` high. Valid words that arrive earlier change nothing. Once a lane is seeded, `deskew_ok` has no further effect.
- R6: In PRBS mode the bits of a lane are taken LSB first and carried across words. Each bit must equal the XOR of the bits DEG and TAP places earlier, with DEG/TAP = 7/6, 15/14, 23/18 or 31/28. The reference state is loaded from the received bits, so one flipped bit at stream position g makes erroneous the words that hold positions g, g+TAP and g+DEG.
- R7: A cycle with `in_valid` low changes no seed, reference, count, flag or lock state.
- R8: `err_sticky[m]` is set by the first erroneous word on lane m and stays set until clear or reset.
- R9: `err_cnt` lane m (bits m*CNT_W+CNT_W-1 down to m*CNT_W) counts the erroneous words on lane m and holds at 2^CNT_W-1.
- R10: `locked[m]` rises after LOCK_LEN (16) consecutive error-free valid words that follow the seed. An erroneous word drops it on the next edge and starts the run again.
- R11: With `rst_n` low, or `clr` high at a rising edge, all lanes become unseeded and all flags, counts and lock bits become 0. `clr` takes priority over any word in the same cycle.
- R12: Every output is registered. The result for a word appears on the rising edge that samples that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of seed, flags, counts and lock |
| deskew_ok | input | 1 | Link alignment indication; enables PRBS seeding |
| in_valid | input | 1 | Qualifies `in_data` for this cycle |
| in_data | input | M*L | Lane m in bits m*L+L-1 down to m*L; L = S*WIDTH_MULP*N |
| err_sticky | output | M | Sticky per-lane error flag |
| err_cnt | output | M*CNT_W | Saturating per-lane erroneous-word counts |
| locked | output | M | Per-lane lock |
| xconv_err | output | 1 | Sticky lane-to-lane mismatch flag (ramp mode) |

## Verification
Every output reflects a word on the rising edge that samples it. The bench therefore drives each word at a falling edge and compares all outputs one time unit after the next rising edge against its own model, which has been updated for that word. In PRBS mode a flipped bit shows up in the word that holds it and possibly in the next word, at offsets (pos+TAP)/L and (pos+DEG)/L. The bench keeps a per-lane queue of words that are due to be flagged. It spaces its injections so that their effects never overlap. The lock edge and the saturation of the counter are sampled on the exact word where they are due.

// File: rtl/pchk_pkg.sv
// Shared types and constants for the pattern checker.
// Assumes PRBS degrees 7, 15, 23 or 31; any other value falls back to degree 31 taps.
package pchk_pkg;

    typedef enum logic {
        MODE_RAMP = 1'b0,
        MODE_PRBS = 1'b1
    } chk_mode_e;

    // Second feedback tap for each supported PRBS degree
    function automatic int prbs_tap(input int deg);
        case (deg)
            7:       return 6;
            15:      return 14;
            23:      return 18;
            default: return 28;
        endcase
    endfunction

endpackage

// File: rtl/pchk_ref.sv
// Per-lane reference tracker. Holds the seeded flag and the expected pattern state,
// and flags a received word that departs from that state.
// Assumes L >= DEG in PRBS mode, so that one word fills the history.
// word_err is meaningful only when valid and seeded are both high; it is 0 otherwise.
module pchk_ref
    import pchk_pkg::*;
#(
    parameter chk_mode_e MODE = MODE_RAMP,
    parameter int        N    = 16,
    parameter int        K    = 2,
    parameter int        DEG  = 31
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           arm,
    input  logic           valid,
    input  logic [N*K-1:0] data,
    output logic           seeded,
    output logic           word_err
);

    localparam int L = N * K;

    logic seeded_q;
    logic mismatch;

    assign seeded   = seeded_q;
    assign word_err = valid & seeded_q & mismatch;

    if (MODE == MODE_RAMP) begin : g_ramp
        logic [N-1:0] ref_q;
        logic [N-1:0] slot_exp;

        // Compare every slot with the reference plus the slot index
        always_comb begin
            mismatch = 1'b0;
            slot_exp = '0;
            for (int k = 0; k < K; k++) begin
                slot_exp = ref_q + N'(k);
                if (data[k*N +: N] != slot_exp) mismatch = 1'b1;
            end
        end

        // Seed from slot 0, then advance by K samples on each valid word
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                seeded_q <= 1'b0;
                ref_q    <= '0;
            end else if (valid) begin
                if (!seeded_q) begin
                    if (arm) begin
                        seeded_q <= 1'b1;
                        ref_q    <= data[N-1:0] + N'(K);
                    end
                end else begin
                    ref_q <= ref_q + N'(K);
                end
            end
        end
    end else begin : g_prbs
        localparam int TAP = prbs_tap(DEG);
        logic [DEG-1:0] hist_q;
        logic [DEG-1:0] hist_w;

        // Predict each bit LSB first from the received history, then shift in the received bit
        always_comb begin
            mismatch = 1'b0;
            hist_w   = hist_q;
            for (int i = 0; i < L; i++) begin
                if (data[i] != (hist_w[DEG-1] ^ hist_w[TAP-1])) mismatch = 1'b1;
                hist_w = {hist_w[DEG-2:0], data[i]};
            end
        end

        // Self-synchronise: the history is always loaded from received bits
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                seeded_q <= 1'b0;
                hist_q   <= '0;
            end else if (valid && (seeded_q || arm)) begin
                seeded_q <= 1'b1;
                hist_q   <= hist_w;
            end
        end
    end

    AST_SEED_GATED: assert property (@(posedge clk) disable iff (!rst_n) (!seeded_q && !arm && !clr) |=> !seeded_q); // R5

endmodule

// File: rtl/pchk_stat.sv
// Per-lane result keeper: sticky flag, saturating error-word count and lock run.
// Assumes word_err is already qualified by valid and seeded.
module pchk_stat #(
    parameter int CNT_W    = 8,
    parameter int LOCK_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             valid,
    input  logic             seeded,
    input  logic             word_err,
    output logic             sticky,
    output logic [CNT_W-1:0] err_cnt,
    output logic             locked
);

    localparam int               SW         = $clog2(LOCK_LEN + 1);
    localparam logic [SW-1:0]    STREAK_TOP = SW'(LOCK_LEN);
    localparam logic [CNT_W-1:0] CNT_MAX    = '1;

    logic             sticky_q;
    logic [CNT_W-1:0] err_cnt_q;
    logic             locked_q;
    logic [SW-1:0]    streak_q;

    assign sticky  = sticky_q;
    assign err_cnt = err_cnt_q;
    assign locked  = locked_q;

    // Track errors and the clean run on every checked word
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sticky_q  <= 1'b0;
            err_cnt_q <= '0;
            locked_q  <= 1'b0;
            streak_q  <= '0;
        end else if (valid && seeded) begin
            if (word_err) begin
                sticky_q <= 1'b1;
                if (err_cnt_q != CNT_MAX) err_cnt_q <= err_cnt_q + 1'b1;
                streak_q <= '0;
                locked_q <= 1'b0;
            end else begin
                if (streak_q != STREAK_TOP) streak_q <= streak_q + 1'b1;
                if (streak_q == STREAK_TOP - 1'b1) locked_q <= 1'b1;
            end
        end
    end

    AST_SEED_NOT_COUNTED: assert property (@(posedge clk) disable iff (!rst_n) (valid && !seeded && !clr) |=> ($stable(err_cnt_q) && $stable(streak_q))); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!valid && !clr) |=> ($stable(err_cnt_q) && $stable(locked_q) && $stable(streak_q) && $stable(sticky_q))); // R7
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (sticky_q && !clr) |=> sticky_q); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (err_cnt_q == CNT_MAX && !clr) |=> err_cnt_q == CNT_MAX); // R9
    AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n) (valid && seeded && word_err && !clr) |=> (!locked_q && streak_q == '0)); // R10
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (err_cnt_q == '0 && !locked_q && !sticky_q)); // R11

endmodule

// File: rtl/pchk_xconv.sv
// Lane-to-lane comparator: sets a sticky flag when any lane differs from lane 0
// on a valid word. Active only in ramp mode; in PRBS mode the flag stays low.
module pchk_xconv
    import pchk_pkg::*;
#(
    parameter chk_mode_e MODE = MODE_RAMP,
    parameter int        M    = 4,
    parameter int        L    = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           valid,
    input  logic [M*L-1:0] data,
    output logic           xconv_err
);

    localparam bit CHECK_ON = (MODE == MODE_RAMP);

    logic differ;
    logic xconv_q;

    assign xconv_err = xconv_q;

    // Look for any lane that is not equal to lane 0
    always_comb begin
        differ = 1'b0;
        for (int m = 1; m < M; m++) begin
            if (data[m*L +: L] != data[0 +: L]) differ = 1'b1;
        end
    end

    // Hold the mismatch flag until clear or reset
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                   xconv_q <= 1'b0;
        else if (CHECK_ON && valid && differ) xconv_q <= 1'b1;
    end

    AST_XCONV_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (xconv_q && !clr) |=> xconv_q); // R4

endmodule

// File: rtl/pattern_checker.sv
// Top of the multi-lane test pattern checker. Splits the bus into M lanes. Each lane
// gets a reference tracker and a result keeper, and a single comparator watches
// for differences between lanes.
// Assumes a single valid for all lanes; outputs are registered (one edge after the word).
module pattern_checker
    import pchk_pkg::*;
#(
    parameter chk_mode_e MODE       = MODE_RAMP,
    parameter int        M          = 4,
    parameter int        S          = 1,
    parameter int        WIDTH_MULP = 2,
    parameter int        N          = 16,
    parameter int        PRBS_DEG   = 31,
    parameter int        CNT_W      = 8,
    parameter int        LOCK_LEN   = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               clr,
    input  logic                               deskew_ok,
    input  logic                               in_valid,
    input  logic [M*S*WIDTH_MULP*N-1:0]        in_data,
    output logic [M-1:0]                       err_sticky,
    output logic [M*CNT_W-1:0]                 err_cnt,
    output logic [M-1:0]                       locked,
    output logic                               xconv_err
);

    localparam int K = S * WIDTH_MULP;
    localparam int L = K * N;

    logic arm_w;

    // Ramp lanes seed on the first valid word; PRBS lanes wait for alignment
    assign arm_w = deskew_ok | (MODE == MODE_RAMP);

    for (genvar m = 0; m < M; m++) begin : g_lane
        logic seeded_w;
        logic word_err_w;

        pchk_ref #(
            .MODE (MODE),
            .N    (N),
            .K    (K),
            .DEG  (PRBS_DEG)
        ) u_ref (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .arm      (arm_w),
            .valid    (in_valid),
            .data     (in_data[m*L +: L]),
            .seeded   (seeded_w),
            .word_err (word_err_w)
        );

        pchk_stat #(
            .CNT_W    (CNT_W),
            .LOCK_LEN (LOCK_LEN)
        ) u_stat (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .valid    (in_valid),
            .seeded   (seeded_w),
            .word_err (word_err_w),
            .sticky   (err_sticky[m]),
            .err_cnt  (err_cnt[m*CNT_W +: CNT_W]),
            .locked   (locked[m])
        );
    end

    pchk_xconv #(
        .MODE (MODE),
        .M    (M),
        .L    (L)
    ) u_xconv (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .valid     (in_valid),
        .data      (in_data),
        .xconv_err (xconv_err)
    );

endmodule

// File: tb/pattern_checker_bench.sv
// Bench for the pattern checker: one ramp-mode and one PRBS-mode instance,
// directed corner cases plus seeded random traffic, compared every cycle with a model.
module pattern_checker_bench;
    import pchk_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int M     = 4;
    localparam int N     = 16;
    localparam int K     = 2;
    localparam int L     = N * K;
    localparam int CNT_W = 8;
    localparam int LOCK  = 16;
    localparam int DEG   = 31;
    localparam int TAP   = 28;
    localparam int CMAX  = 255;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic           r_clr = 1'b0, r_valid = 1'b0;
    logic [M*L-1:0] r_data = '0;
    logic [M-1:0]   r_sticky, r_lock;
    logic [M*CNT_W-1:0] r_cnt;
    logic           r_xc;

    logic           p_clr = 1'b0, p_valid = 1'b0, p_align = 1'b0;
    logic [M*L-1:0] p_data = '0;
    logic [M-1:0]   p_sticky, p_lock;
    logic [M*CNT_W-1:0] p_cnt;
    logic           p_xc;

    int n_checks = 0;
    int n_err    = 0;

    // model state, index 0 = ramp instance, 1 = PRBS instance
    bit e_seed[2][M];
    bit e_sticky[2][M];
    int e_cnt[2][M];
    int e_streak[2][M];
    bit e_lock[2][M];
    bit e_xc[2];

    logic [N-1:0]  rr = '0;
    logic [30:0]   gen = 31'h2B1C_0F35;
    logic [3:0]    pend[M];

    always #(CLK_PERIOD/2) clk = ~clk;

    pattern_checker #(.MODE(MODE_RAMP), .M(M), .S(1), .WIDTH_MULP(2), .N(N),
                      .PRBS_DEG(DEG), .CNT_W(CNT_W), .LOCK_LEN(LOCK)) u_pattern_checker (
        .clk(clk), .rst_n(rst_n), .clr(r_clr), .deskew_ok(1'b0), .in_valid(r_valid),
        .in_data(r_data), .err_sticky(r_sticky), .err_cnt(r_cnt), .locked(r_lock),
        .xconv_err(r_xc));

    pattern_checker #(.MODE(MODE_PRBS), .M(M), .S(1), .WIDTH_MULP(2), .N(N),
                      .PRBS_DEG(DEG), .CNT_W(CNT_W), .LOCK_LEN(LOCK)) u_pattern_checker_prbs (
        .clk(clk), .rst_n(rst_n), .clr(p_clr), .deskew_ok(p_align), .in_valid(p_valid),
        .in_data(p_data), .err_sticky(p_sticky), .err_cnt(p_cnt), .locked(p_lock),
        .xconv_err(p_xc));

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    task automatic check_eq(string req, string what, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset(int d);
        for (int m = 0; m < M; m++) begin
            e_seed[d][m] = 0; e_sticky[d][m] = 0; e_cnt[d][m] = 0;
            e_streak[d][m] = 0; e_lock[d][m] = 0;
            if (d == 1) pend[m] = '0;
        end
        e_xc[d] = 0;
    endtask

    task automatic model_word(int d, bit arm, bit [M-1:0] bad, bit xmis);
        for (int m = 0; m < M; m++) begin
            if (!e_seed[d][m]) begin
                if (arm) e_seed[d][m] = 1;
            end else if (bad[m]) begin
                e_sticky[d][m] = 1;
                if (e_cnt[d][m] < CMAX) e_cnt[d][m]++;
                e_streak[d][m] = 0;
                e_lock[d][m] = 0;
            end else begin
                if (e_streak[d][m] < LOCK) e_streak[d][m]++;
                if (e_streak[d][m] == LOCK) e_lock[d][m] = 1;
            end
        end
        if (d == 0 && xmis) e_xc[0] = 1;
    endtask

    task automatic compare(int d, string req);
        logic [M-1:0] es, el, as_, al;
        logic [M*CNT_W-1:0] ec, ac;
        logic ex, ax;
        for (int m = 0; m < M; m++) begin
            es[m] = e_sticky[d][m];
            el[m] = e_lock[d][m];
            ec[m*CNT_W +: CNT_W] = CNT_W'(e_cnt[d][m]);
        end
        ex = e_xc[d];
        if (d == 0) begin as_ = r_sticky; al = r_lock; ac = r_cnt; ax = r_xc; end
        else        begin as_ = p_sticky; al = p_lock; ac = p_cnt; ax = p_xc; end
        n_checks++;
        if (as_ !== es || al !== el || ac !== ec || ax !== ex) begin
            n_err++;
            $display("FAIL %s dut%0d: sticky %h/%h lock %h/%h cnt %h/%h xconv %b/%b (actual/expected)",
                     req, d, as_, es, al, el, ac, ec, ax, ex);
        end
    endtask

    // One ramp word (or idle cycle); corrupt flips bit 3 of slot 1, all_c flips bit 5 of slot 0 on every lane
    task automatic r_cycle(bit v, bit [M-1:0] corrupt, bit all_c, string req);
        logic [N-1:0] s;
        @(negedge clk);
        if (v) begin
            for (int m = 0; m < M; m++)
                for (int k = 0; k < K; k++) begin
                    s = rr + N'(k);
                    if (corrupt[m] && k == 1) s = s ^ 16'h0008;
                    if (all_c && k == 0) s = s ^ 16'h0020;
                    r_data[m*L + k*N +: N] = s;
                end
            rr = rr + N'(K);
        end else begin
            r_data = {$urandom, $urandom, $urandom, $urandom};
        end
        r_valid = v;
        @(posedge clk); #1;
        if (v) model_word(0, 1'b1, corrupt | {M{all_c}}, corrupt != '0);
        compare(0, req);
    endtask

    // One PRBS word (or idle cycle); inj flips bit pos on the selected lanes
    task automatic p_cycle(bit v, bit [M-1:0] inj, int pos, string req);
        logic [L-1:0] w;
        bit [M-1:0] bad;
        logic [3:0] nb;
        logic b;
        @(negedge clk);
        if (v) begin
            for (int i = 0; i < L; i++) begin
                b = gen[30] ^ gen[27];
                w[i] = b;
                gen = {gen[29:0], b};
            end
            for (int m = 0; m < M; m++)
                p_data[m*L +: L] = w ^ (inj[m] ? (32'd1 << pos) : 32'd0);
        end else begin
            p_data = {$urandom, $urandom, $urandom, $urandom};
        end
        p_valid = v;
        @(posedge clk); #1;
        if (v) begin
            for (int m = 0; m < M; m++) begin
                nb = '0;
                if (inj[m]) begin
                    nb[0] = 1'b1;
                    nb[(pos + TAP) / L] = 1'b1;
                    nb[(pos + DEG) / L] = 1'b1;
                end
                bad[m] = pend[m][0] | nb[0];
                pend[m] = (pend[m] | nb) >> 1;
            end
            model_word(1, p_align, bad, 1'b0);
        end
        compare(1, req);
    endtask

    task automatic do_clear(int d);
        @(negedge clk);
        if (d == 0) begin r_clr = 1; r_valid = 1; end else begin p_clr = 1; p_valid = 1; end
        @(posedge clk); #1;
        model_reset(d);
        compare(d, "R11");
        @(negedge clk);
        r_clr = 0; p_clr = 0; r_valid = 0; p_valid = 0;
    endtask

    // Watchdog: a hung run ends as a failure
    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL R12 watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        int gap;
        bit [M-1:0] c;
        void'($urandom(32'd20240611));
        model_reset(0);
        model_reset(1);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        check_eq("R11", "reset ramp outputs", {r_sticky, r_lock, r_cnt, r_xc}, '0);
        check_eq("R11", "reset prbs outputs", {p_sticky, p_lock, p_cnt, p_xc}, '0);

        // ---------------- ramp mode ----------------
        rr = 16'hFFF0;
        r_cycle(1, '0, 0, "R1");                                 // seed word
        check_eq("R1", "cnt after seed", r_cnt, '0);
        for (int i = 0; i < LOCK - 1; i++) r_cycle(1, '0, 0, "R3");
        check_eq("R10", "lock after 15 clean", r_lock, '0);
        r_cycle(1, '0, 0, "R10");
        check_eq("R10", "lock after 16 clean", r_lock, 4'hF);
        check_eq("R3", "no error across wrap", r_sticky, '0);
        for (int i = 0; i < 5; i++) r_cycle(0, '0, 0, "R7");
        check_eq("R7", "lock held over idle", r_lock, 4'hF);
        r_cycle(1, 4'b0010, 0, "R2");
        check_eq("R2", "lane1 count", r_cnt[1*CNT_W +: CNT_W], 8'd1);
        check_eq("R4", "xconv set", r_xc, 1'b1);
        check_eq("R10", "lane1 lock dropped", r_lock, 4'b1101);
        for (int i = 0; i < 3; i++) r_cycle(1, '0, 0, "R8");
        check_eq("R8", "lane1 sticky held", r_sticky, 4'b0010);

        do_clear(0);
        rr = 16'h1234;
        r_cycle(1, '0, 0, "R1");
        r_cycle(1, '0, 0, "R2");
        r_cycle(1, '0, 1, "R4");
        check_eq("R4", "identical corruption sets all lanes", r_sticky, 4'hF);
        check_eq("R4", "identical corruption no xconv", r_xc, 1'b0);

        for (int i = 0; i < 300; i++) begin
            c = ($urandom % 16 == 0) ? (4'b0001 << ($urandom % M)) : 4'b0000;
            r_cycle(($urandom % 4) != 0, c, 0, "R8");
        end

        do_clear(0);
        r_cycle(1, '0, 0, "R1");
        for (int i = 0; i < 260; i++) r_cycle(1, 4'b0100, 0, "R9");
        check_eq("R9", "lane2 count saturated", r_cnt[2*CNT_W +: CNT_W], 8'hFF);
        check_eq("R9", "lane0 count", r_cnt[0 +: CNT_W], 8'h00);

        // ---------------- PRBS mode ----------------
        p_align = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            p_data = {$urandom, $urandom, $urandom, $urandom};
            p_valid = 1;
            @(posedge clk); #1;
            model_word(1, 1'b0, '0, 1'b0);
            compare(1, "R5");
        end
        check_eq("R5", "no lock before alignment", p_lock, '0);
        check_eq("R5", "no count before alignment", p_cnt, '0);
        p_align = 1;
        p_cycle(1, '0, 0, "R1");
        for (int i = 0; i < LOCK; i++) p_cycle(1, '0, 0, "R6");
        check_eq("R6", "prbs locked", p_lock, 4'hF);
        check_eq("R4", "prbs xconv stays low", p_xc, 1'b0);
        p_cycle(1, 4'b0001, 0, "R6");
        for (int i = 0; i < 4; i++) p_cycle(1, '0, 0, "R6");
        check_eq("R6", "bit0 flip -> one word", p_cnt[0 +: CNT_W], 8'd1);
        p_cycle(1, 4'b0010, 10, "R6");
        for (int i = 0; i < 4; i++) p_cycle(1, '0, 0, "R6");
        check_eq("R6", "bit10 flip -> two words", p_cnt[1*CNT_W +: CNT_W], 8'd2);
        p_align = 0;
        p_cycle(1, 4'b0100, 5, "R5");
        for (int i = 0; i < 4; i++) p_cycle(1, '0, 0, "R5");
        check_eq("R5", "checking continues without alignment", p_cnt[2*CNT_W +: CNT_W], 8'd2);
        p_align = 1;

        gap = 0;
        for (int i = 0; i < 300; i++) begin
            bit v;
            v = ($urandom % 4) != 0;
            if (v && gap >= 4 && ($urandom % 8 == 0)) begin
                p_cycle(1, 4'b0001 << ($urandom % M), int'($urandom % L), "R6");
                gap = 0;
            end else begin
                p_cycle(v, '0, 0, "R7");
                if (v) gap++;
            end
        end

        do_clear(1);
        p_align = 0;
        for (int i = 0; i < 20; i++) p_cycle(1, '0, 0, "R11");
        check_eq("R11", "unseeded after clear", p_lock, '0);

        summary();
        $finish;
    end

endmodule